// File: doc/BRIEF.md
# Two-Lane Crosstalk-Cancelling PAM-4 Adaptive Equalizer

This block is the digital equalizer at the back of a two-lane wireline receiver. It sits after the converters. Each lane delivers signed samples, and the two lanes share one strobe. For every lane the block adds up three things: a feedforward filter over that lane's own recent samples, a matching set of taps over the neighbour lane's samples, and one feedback tap on each lane's previous decision. The taps over the neighbour lane remove far-end crosstalk. The feedback taps remove post-cursor interference, again across both lanes. The sum is saturated, then sliced to one of four amplitude levels, and sent out as a Gray-coded symbol together with the slicer error.

Every coefficient adapts by least-mean-square. Each one moves by the error times the value it multiplies, scaled down by a shift that software selects. The block runs continuously on the strobe and needs no other control. Adaptation can be frozen at any time.

Top module: `pam4_mimo_eq`

## Requirements
- R1: While rst is high and after it falls, out_valid is 0, both symbols are 00 and both errors are 0. The self-lane tap at delay index 7 (index 0 is the newest sample) holds 256, which is unity with 8 fraction bits. Every other tap and both stored decisions hold 0.
- R2: A sample pair accepted at rising edge k (in_valid high) produces both lanes' results together. out_valid is high from edge k+1 to edge k+2, once per accepted pair.
- R3: With reset coefficients and adaptation off, each lane's equalized value equals its own sample from 7 accepted strobes earlier. The other lane contributes nothing.
- R4: With unit level L=32, the slicer picks +3L (code 10) when y >= 64, +L (code 11) when 0 <= y < 64, -L (code 01) when -64 <= y < 0, and -3L (code 00) below -64.
- R5: The error is the decided level minus the saturated equalized value, so it always lies in [-31, 32].
- R6: The equalized value is the sum of coef×sample over 15 self taps and 15 neighbour taps, plus coef×previous-decision-level for both lanes. This sum is arithmetically shifted right by 8 and saturated to [-128, 127]. The sum never wraps.
- R7: With adapt_en high, every coefficient becomes sat12(c + ((err × v) >>> mu_shift)) on each accepted pair. Here v is the sample or previous decision level (±32, ±96) that the coefficient multiplies. sat12 clamps to [-2048, 2047].
- R8: With adapt_en low, no coefficient changes.
- R9: Cycles with in_valid low change no state and produce no result, whatever in_a and in_b carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Common strobe for both lanes' samples |
| in_a | input | 8 | Lane A sample, signed |
| in_b | input | 8 | Lane B sample, signed |
| adapt_en | input | 1 | Enables coefficient adaptation |
| mu_shift | input | 4 | Step-size right shift |
| out_valid | output | 1 | Result strobe for both lanes |
| sym_a | output | 2 | Lane A Gray-coded decision |
| sym_b | output | 2 | Lane B Gray-coded decision |
| err_a | output | 8 | Lane A slicer error, signed |
| err_b | output | 8 | Lane B slicer error, signed |

## Verification
The assertions take for granted that in_valid is held low throughout reset. This lets the latency property look two cycles back without picking up a stray strobe, and the bench drives it low from time zero. They also take for granted that the stored coefficients move only on an accepted pair with adaptation on. The bench therefore changes adapt_en and mu_shift only after the pipeline has drained, so the value in force when a step fires is the one the model used. Gaps in the stimulus carry random data with the strobe low. This exercises the assumption that idle cycles touch nothing.

// File: rtl/pam4_eq_pkg.sv
package pam4_eq_pkg;
  localparam int SAMP_W    = 8;
  localparam int COEF_W    = 12;
  localparam int COEF_FRAC = 8;
  localparam int NTAP      = 15;
  localparam int LEVEL     = 32;
  localparam int ERR_W     = 8;
  localparam int MU_W      = 4;

  // clamp a value into a signed field of w bits
  function automatic int clip(int v, int w);
    int hi;
    int lo;
    hi = (1 << (w - 1)) - 1;
    lo = -(1 << (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // four-level decision, returned as an amplitude
  function automatic int decide(int y, int lvl);
    if (y >= 2 * lvl) return 3 * lvl;
    if (y >= 0)       return lvl;
    if (y >= -2 * lvl) return -lvl;
    return -3 * lvl;
  endfunction

  function automatic logic [1:0] gray_code(int d, int lvl);
    if (d == 3 * lvl) return 2'b10;
    if (d == lvl)     return 2'b11;
    if (d == -lvl)    return 2'b01;
    return 2'b00;
  endfunction

  // one least-mean-square move of a single coefficient
  function automatic int lms_step(int c, int e, int x, int mu, int w);
    return clip(c + ((e * x) >>> mu), w);
  endfunction
endpackage

// File: rtl/eq_tap_line.sv
module eq_tap_line #(
  parameter int NT = 15,
  parameter int SW = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   shift,
  input  logic [SW-1:0]          din,
  output logic [NT-1:0][SW-1:0]  taps
);
  always_ff @(posedge clk) begin
    if (rst)        taps <= '0;
    else if (shift) taps <= {taps[NT-2:0], din};
  end
endmodule

// File: rtl/eq_coef_bank.sv
module eq_coef_bank
  import pam4_eq_pkg::*;
#(
  parameter int NT = 15,
  parameter int SW = 8,
  parameter int CW = 12,
  parameter int CF = 8,
  parameter int EW = 8,
  parameter int MW = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  upd,
  input  logic [MW-1:0]         mu,
  input  logic [EW-1:0]         err,
  input  logic [NT-1:0][SW-1:0] own_x,
  input  logic [NT-1:0][SW-1:0] cross_x,
  input  logic [SW-1:0]         d_own,
  input  logic [SW-1:0]         d_cross,
  output logic [NT-1:0][CW-1:0] c_own,
  output logic [NT-1:0][CW-1:0] c_cross,
  output logic [CW-1:0]         c_fbo,
  output logic [CW-1:0]         c_fbx
);
  localparam int CTR = NT / 2;
  localparam logic [CW-1:0] UNITY = CW'(1 << CF);

  int e_i;
  assign e_i = int'($signed(err));

  for (genvar k = 0; k < NT; k++) begin : g_tap
    logic [CW-1:0] own_q;
    logic [CW-1:0] crs_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        own_q <= (k == CTR) ? UNITY : '0;
        crs_q <= '0;
      end else if (upd) begin
        own_q <= CW'(lms_step(int'($signed(own_q)), e_i, int'($signed(own_x[k])), int'(mu), CW));
        crs_q <= CW'(lms_step(int'($signed(crs_q)), e_i, int'($signed(cross_x[k])), int'(mu), CW));
      end
    end
    assign c_own[k]   = own_q;
    assign c_cross[k] = crs_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c_fbo <= '0;
      c_fbx <= '0;
    end else if (upd) begin
      c_fbo <= CW'(lms_step(int'($signed(c_fbo)), e_i, int'($signed(d_own)), int'(mu), CW));
      c_fbx <= CW'(lms_step(int'($signed(c_fbx)), e_i, int'($signed(d_cross)), int'(mu), CW));
    end
  end
endmodule

// File: rtl/eq_lane_filter.sv
module eq_lane_filter
  import pam4_eq_pkg::*;
#(
  parameter int NT  = 15,
  parameter int SW  = 8,
  parameter int CW  = 12,
  parameter int CF  = 8,
  parameter int LVL = 32,
  parameter int EW  = 8
) (
  input  logic [NT-1:0][SW-1:0] own_x,
  input  logic [NT-1:0][SW-1:0] cross_x,
  input  logic [NT-1:0][CW-1:0] c_own,
  input  logic [NT-1:0][CW-1:0] c_cross,
  input  logic [CW-1:0]         c_fbo,
  input  logic [CW-1:0]         c_fbx,
  input  logic [SW-1:0]         d_own,
  input  logic [SW-1:0]         d_cross,
  output logic [SW-1:0]         lvl,
  output logic [1:0]            sym,
  output logic [EW-1:0]         err
);
  localparam int AW = SW + CW + $clog2(2 * NT + 2) + 1;

  logic signed [AW-1:0] acc;
  int y_i;
  int l_i;

  always_comb begin
    acc = '0;
    for (int k = 0; k < NT; k++) begin
      acc = acc + AW'($signed(own_x[k])) * AW'($signed(c_own[k]))
                + AW'($signed(cross_x[k])) * AW'($signed(c_cross[k]));
    end
    acc = acc + AW'($signed(d_own)) * AW'($signed(c_fbo))
              + AW'($signed(d_cross)) * AW'($signed(c_fbx));
    y_i = clip(int'(acc >>> CF), SW);
    l_i = decide(y_i, LVL);
    lvl = SW'(l_i);
    sym = gray_code(l_i, LVL);
    err = EW'(l_i - y_i);
  end
endmodule

// File: rtl/pam4_mimo_eq.sv
module pam4_mimo_eq
  import pam4_eq_pkg::*;
#(
  parameter int NT  = NTAP,
  parameter int SW  = SAMP_W,
  parameter int CW  = COEF_W,
  parameter int CF  = COEF_FRAC,
  parameter int LVL = LEVEL,
  parameter int EW  = ERR_W,
  parameter int MW  = MU_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [SW-1:0] in_a,
  input  logic [SW-1:0] in_b,
  input  logic          adapt_en,
  input  logic [MW-1:0] mu_shift,
  output logic          out_valid,
  output logic [1:0]    sym_a,
  output logic [1:0]    sym_b,
  output logic [EW-1:0] err_a,
  output logic [EW-1:0] err_b
);
  localparam int CTR = NT / 2;
  localparam int BW  = (2 * NT + 2) * CW;

  logic [SW-1:0]         din    [2];
  logic [NT-1:0][SW-1:0] line   [2];
  logic [NT-1:0][CW-1:0] cw_own [2];
  logic [NT-1:0][CW-1:0] cw_crs [2];
  logic [CW-1:0]         cw_fbo [2];
  logic [CW-1:0]         cw_fbx [2];
  logic [SW-1:0]         dec_q  [2];
  logic [SW-1:0]         fs_lvl [2];
  logic [1:0]            fs_sym [2];
  logic [EW-1:0]         fs_err [2];
  logic [1:0]            sym_q  [2];
  logic [EW-1:0]         err_q  [2];

  // named events for the checker
  logic                  step_q;
  logic                  step_fire;
  logic                  upd_fire;
  logic [1:0][CW-1:0]    ctr_w;
  logic [1:0][BW-1:0]    bank_flat;

  assign din[0]    = in_a;
  assign din[1]    = in_b;
  assign step_fire = step_q;
  assign upd_fire  = step_q & adapt_en;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    eq_tap_line #(.NT(NT), .SW(SW)) line_i (
      .clk(clk), .rst(rst), .shift(in_valid), .din(din[g]), .taps(line[g])
    );

    eq_coef_bank #(.NT(NT), .SW(SW), .CW(CW), .CF(CF), .EW(EW), .MW(MW)) bank_i (
      .clk(clk), .rst(rst), .upd(upd_fire), .mu(mu_shift), .err(fs_err[g]),
      .own_x(line[g]), .cross_x(line[1-g]), .d_own(dec_q[g]), .d_cross(dec_q[1-g]),
      .c_own(cw_own[g]), .c_cross(cw_crs[g]), .c_fbo(cw_fbo[g]), .c_fbx(cw_fbx[g])
    );

    eq_lane_filter #(.NT(NT), .SW(SW), .CW(CW), .CF(CF), .LVL(LVL), .EW(EW)) filt_i (
      .own_x(line[g]), .cross_x(line[1-g]), .c_own(cw_own[g]), .c_cross(cw_crs[g]),
      .c_fbo(cw_fbo[g]), .c_fbx(cw_fbx[g]), .d_own(dec_q[g]), .d_cross(dec_q[1-g]),
      .lvl(fs_lvl[g]), .sym(fs_sym[g]), .err(fs_err[g])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        dec_q[g] <= '0;
        sym_q[g] <= '0;
        err_q[g] <= '0;
      end else if (step_q) begin
        dec_q[g] <= fs_lvl[g];
        sym_q[g] <= fs_sym[g];
        err_q[g] <= fs_err[g];
      end
    end

    assign ctr_w[g]     = cw_own[g][CTR];
    assign bank_flat[g] = {cw_own[g], cw_crs[g], cw_fbo[g], cw_fbx[g]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q    <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      step_q    <= in_valid;
      out_valid <= step_q;
    end
  end

  assign sym_a = sym_q[0];
  assign sym_b = sym_q[1];
  assign err_a = err_q[0];
  assign err_b = err_q[1];
endmodule

// File: rtl/pam4_mimo_eq_chk.sv
module pam4_mimo_eq_chk #(
  parameter int CW  = 12,
  parameter int CF  = 8,
  parameter int EW  = 8,
  parameter int LVL = 32,
  parameter int BW  = 384
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                out_valid,
  input logic                step_fire,
  input logic                upd_fire,
  input logic [EW-1:0]       err_a,
  input logic [EW-1:0]       err_b,
  input logic [1:0][CW-1:0]  ctr_w,
  input logic [1:0][BW-1:0]  bank_flat
);
  a_r1_unity_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ctr_w[0] == CW'(1 << CF) && ctr_w[1] == CW'(1 << CF) && !out_valid));

  a_r2_result_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));

  a_r5_err_range_a: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($signed(err_a) >= -(LVL - 1) && $signed(err_a) <= LVL));

  a_r5_err_range_b: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($signed(err_b) >= -(LVL - 1) && $signed(err_b) <= LVL));

  a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
    !upd_fire |=> $stable(bank_flat));

  a_r9_idle_no_step: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !step_fire);
endmodule

bind pam4_mimo_eq pam4_mimo_eq_chk #(
  .CW(CW), .CF(CF), .EW(EW), .LVL(LVL), .BW((2 * NT + 2) * CW)
) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .step_fire(step_fire), .upd_fire(upd_fire), .err_a(err_a), .err_b(err_b),
  .ctr_w(ctr_w), .bank_flat(bank_flat)
);

// File: tb/pam4_mimo_eq_tb_top.sv
module pam4_mimo_eq_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_a = '0;
  logic [7:0] in_b = '0;
  logic       adapt_en = 1'b0;
  logic [3:0] mu_shift = '0;
  logic       out_valid;
  logic [1:0] sym_a, sym_b;
  logic [7:0] err_a, err_b;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pam4_mimo_eq dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .adapt_en(adapt_en), .mu_shift(mu_shift), .out_valid(out_valid),
    .sym_a(sym_a), .sym_b(sym_b), .err_a(err_a), .err_b(err_b)
  );

  // ---- reference model, restated from the requirements ----
  typedef struct { int sa; int sb; int ea; int eb; int ph; } exp_t;
  exp_t q[$];

  int mc [2][15];
  int mx [2][15];
  int mfo[2];
  int mfx[2];
  int hs [2][15];
  int dk [2];

  function automatic string tag(int ph);
    case (ph)
      2: return "R2"; 3: return "R3"; 4: return "R4";
      6: return "R6"; 7: return "R7"; 8: return "R8"; 9: return "R9";
      default: return "R?";
    endcase
  endfunction

  function automatic int lim(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  task automatic model_reset();
    for (int l = 0; l < 2; l++) begin
      for (int k = 0; k < 15; k++) begin
        mc[l][k] = (k == 7) ? 256 : 0;
        mx[l][k] = 0;
        hs[l][k] = 0;
      end
      mfo[l] = 0; mfx[l] = 0; dk[l] = 0;
    end
  endtask

  task automatic model_step(int a, int b, int ph);
    int y[2], lv[2], e[2], code[2];
    int gray[4] = '{0, 1, 3, 2};
    exp_t it;
    for (int k = 14; k > 0; k--) begin
      hs[0][k] = hs[0][k-1];
      hs[1][k] = hs[1][k-1];
    end
    hs[0][0] = a; hs[1][0] = b;
    for (int l = 0; l < 2; l++) begin
      int s = 0;
      int idx;
      for (int k = 0; k < 15; k++) s += mc[l][k] * hs[l][k] + mx[l][k] * hs[1-l][k];
      s += mfo[l] * dk[l] + mfx[l] * dk[1-l];
      y[l] = lim(s >>> 8, -128, 127);
      idx = (y[l] >= 64 ? 1 : 0) + (y[l] >= 0 ? 1 : 0) + (y[l] >= -64 ? 1 : 0);
      lv[l] = (2 * idx - 3) * 32;
      code[l] = gray[idx];
      e[l] = lv[l] - y[l];
    end
    if (adapt_en) begin
      for (int l = 0; l < 2; l++) begin
        for (int k = 0; k < 15; k++) begin
          mc[l][k] = lim(mc[l][k] + ((e[l] * hs[l][k]) >>> mu_shift), -2048, 2047);
          mx[l][k] = lim(mx[l][k] + ((e[l] * hs[1-l][k]) >>> mu_shift), -2048, 2047);
        end
        mfo[l] = lim(mfo[l] + ((e[l] * dk[l]) >>> mu_shift), -2048, 2047);
        mfx[l] = lim(mfx[l] + ((e[l] * dk[1-l]) >>> mu_shift), -2048, 2047);
      end
    end
    dk[0] = lv[0]; dk[1] = lv[1];
    it.sa = code[0]; it.sb = code[1]; it.ea = e[0]; it.eb = e[1]; it.ph = ph;
    q.push_back(it);
  endtask

  // ---- checks ----
  task automatic check(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // ---- driver ----
  task automatic send(int a, int b, int ph);
    @(negedge clk);
    in_valid = 1'b1;
    in_a = a[7:0];
    in_b = b[7:0];
    model_step(a, b, ph);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_a = 8'($urandom);
      in_b = 8'($urandom);
    end
  endtask

  task automatic set_mode(bit en, int mu);
    idle(4);
    adapt_en = en;
    mu_shift = 4'(mu);
  endtask

  function automatic int pam(int idx);
    return (2 * idx - 3) * 32;
  endfunction

  // ---- monitor ----
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R2", "unexpected out_valid", 1, 0);
      end else begin
        exp_t it;
        it = q.pop_front();
        check(int'(sym_a) == it.sa, tag(it.ph), "sym_a", int'(sym_a), it.sa);
        check(int'($signed(err_a)) == it.ea, tag(it.ph), "err_a", int'($signed(err_a)), it.ea);
        check(int'(sym_b) == it.sb, tag(it.ph), "sym_b", int'(sym_b), it.sb);
        check(int'($signed(err_b)) == it.eb, tag(it.ph), "err_b", int'($signed(err_b)), it.eb);
      end
    end
  end

  // ---- watchdog ----
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R2", "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---- stimulus ----
  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    check(sym_a == 2'b00 && sym_b == 2'b00, "R1", "symbols in reset", int'({sym_a, sym_b}), 0);
    check(err_a == '0 && err_b == '0, "R1", "errors in reset", int'({err_a, err_b}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

    // R3: pass-through with reset taps, no cross contribution
    set_mode(1'b0, 0);
    for (int i = 0; i < 40; i++) send(pam($urandom_range(0, 3)), $urandom_range(0, 255) - 128, 3);

    // R2: single pair latency
    idle(4);
    send(96, -96, 2);
    idle(1);
    check(out_valid == 1'b0, "R2", "out_valid one edge after accept", int'(out_valid), 0);
    idle(1);
    check(out_valid == 1'b1, "R2", "out_valid two edges after accept", int'(out_valid), 1);
    idle(1);
    check(out_valid == 1'b0, "R2", "out_valid pulse width", int'(out_valid), 0);

    // R4 / R5: full slicer sweep through the reset pass-through
    for (int v = 0; v < 256; v++) send(v - 128, 127 - v, 4);
    for (int i = 0; i < 8; i++) send(0, 0, 4);

    // R7: adaptation on a coupled two-lane channel
    set_mode(1'b1, 9);
    for (int i = 0; i < 400; i++) begin
      int pa, pb;
      pa = pam($urandom_range(0, 3));
      pb = pam($urandom_range(0, 3));
      send(lim(pa + pb / 4 + $urandom_range(0, 8) - 4, -128, 127),
           lim(pb + pa / 4 + $urandom_range(0, 8) - 4, -128, 127), 7);
    end

    // R8: frozen coefficients
    set_mode(1'b0, 9);
    for (int i = 0; i < 150; i++) begin
      int pa, pb;
      pa = pam($urandom_range(0, 3));
      pb = pam($urandom_range(0, 3));
      send(lim(pa + pb / 4, -128, 127), lim(pb + pa / 4, -128, 127), 8);
    end

    // R9: idle cycles with junk data between accepted pairs
    set_mode(1'b1, 8);
    for (int i = 0; i < 200; i++) begin
      send(pam($urandom_range(0, 3)) + $urandom_range(0, 6) - 3,
           pam($urandom_range(0, 3)) + $urandom_range(0, 6) - 3, 9);
      idle($urandom_range(0, 3));
    end

    // R6: large inputs, full step size, saturating sums and coefficients
    set_mode(1'b1, 0);
    for (int i = 0; i < 100; i++) send($urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128, 6);

    idle(6);
    check(q.size() == 0, "R2", "results outstanding", q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule